// File: doc/BRIEF.md
# Low-Power DDR Power-Up Command Sequencer

This block walks a low-power DDR1 SDRAM from power-up to its working state. A host first writes a mode code into the block. It then makes a separate acknowledging access, and only that access puts the matching command on the memory command bus. The block enforces a fixed order of commands:

1. A NOP, which also turns on clock enable.
2. A hold of at least 200 µs.
3. A precharge of every bank.
4. Two auto-refreshes.
5. A load of the extended mode register, which carries the self-refresh temperature setting, the partial-array setting and the drive strength.
6. A load of the standard mode register, which carries CAS latency and burst length.

An access that does not fit the sequence raises a one-cycle error pulse. It issues no command and leaves the sequence where it was.

When the standard mode register load goes out, the block raises a ready flag and keeps it high. From then on, a refresh request pulse appears each time a programmable interval expires. At 100 MHz that interval is 1562 cycles for a 15.625 µs period, or 781 cycles for 7.81 µs. The hold length is a cycle count derived from the clock frequency and the hold time in microseconds.

Top module: `lpd_init_sequencer`

## Requirements
- R1: While reset is asserted, the outputs are as follows. Clock enable is low. Chip select, RAS, CAS and WE (all active low) are high. Bank address and address are zero. Ready, refresh request and error are low.
- R2: The codes are 1 for NOP, 2 for precharge all, 4 for auto-refresh, 5 for extended mode load and 3 for standard mode load. A code write stores the code. An acknowledging access uses the code stored at an earlier edge. The commands must be accepted in this order: NOP, precharge all, refresh, refresh, extended load, standard load.
- R3: An accepted command appears in the cycle after the edge that samples the acknowledge, and it lasts exactly one cycle. The bus then returns to the NOP encoding: select low, the other three strobes high, bank address and address zero. The encodings are:
  - precharge all: RAS=0, CAS=1, WE=0
  - refresh: RAS=0, CAS=0, WE=1
  - either mode load: RAS=0, CAS=0, WE=0
- R4: The NOP step raises clock enable and drives select low from the next cycle onward. Clock enable never falls again.
- R5: Acknowledges sampled on the WAIT_CYCLES edges that follow the NOP edge are rejected. WAIT_CYCLES equals CLK_MHZ times WAIT_US. The first acknowledge that can be accepted is sampled on the edge after that.
- R6: Precharge all drives address bit 10 high, every other address bit low, and bank address 00.
- R7: Exactly two refresh commands are required, and each one needs its own acknowledge.
- R8: The extended mode load drives bank address 10 (bit 1 set, bit 0 clear), with the address taken from extModeBits.
- R9: The standard mode load drives bank address 00, with the address taken from modeBits.
- R10: The following acknowledges are rejected: one with a wrong stored code, one during the hold, and any after ready. A rejected acknowledge gives a one-cycle error pulse in the next cycle, issues no command and does not advance the sequence.
- R11: Ready rises in the same cycle that the standard mode load appears on the bus, and it stays high.
- R12: Once ready is high, refresh request pulses for one cycle every N cycles. The first pulse comes N cycles after ready rises. N is refreshCount, sampled at each reload, and a value of zero counts as one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| hostModeWr | input | 1 | Stores hostModeCode |
| hostModeCode | input | 3 | Command code |
| hostAck | input | 1 | Acknowledging access that issues the stored command |
| extModeBits | input | ADDR_W | Address value for the extended mode load |
| modeBits | input | ADDR_W | Address value for the standard mode load |
| refreshCount | input | REF_W | Refresh interval in cycles |
| memCke | output | 1 | Clock enable |
| memCsN | output | 1 | Chip select, active low |
| memRasN | output | 1 | Row strobe, active low |
| memCasN | output | 1 | Column strobe, active low |
| memWeN | output | 1 | Write enable, active low |
| memBa | output | 2 | Bank address |
| memAddr | output | ADDR_W | Address |
| initReady | output | 1 | Initialization complete |
| refreshReq | output | 1 | One-cycle refresh request |
| seqError | output | 1 | One-cycle pulse for a rejected acknowledge |

## Verification
Every command, the clock enable rise, the ready rise and the error pulse are due one cycle after the edge that samples the acknowledge. Refresh pulses are due N cycles after ready rises and then every N cycles. The bench keeps a behavioural model that advances on the same edges and compares every output at the falling edge, so each result is read after its register has updated. Acknowledges are placed on the last rejected edge and on the first accepted edge of the hold, so the R5 boundary is checked from both sides.

// File: rtl/lpd_init_pkg.sv
package lpd_init_pkg;

  localparam logic [2:0] CODE_NOP  = 3'd1;
  localparam logic [2:0] CODE_PREA = 3'd2;
  localparam logic [2:0] CODE_MRS  = 3'd3;
  localparam logic [2:0] CODE_REF  = 3'd4;
  localparam logic [2:0] CODE_EMRS = 3'd5;

  typedef enum logic [3:0] {
    ST_NOP, ST_WAIT, ST_PREA, ST_REF1, ST_REF2, ST_EMRS, ST_MRS, ST_READY
  } seqState_e;

  typedef struct packed {
    logic issueNop;
    logic issuePrea;
    logic issueRef;
    logic issueEmrs;
    logic issueMrs;
    logic flagError;
  } seqStrobe_t;

  typedef struct packed {
    logic csN;
    logic rasN;
    logic casN;
    logic weN;
  } memCmd_t;

  localparam memCmd_t CMD_DESEL = '{csN: 1'b1, rasN: 1'b1, casN: 1'b1, weN: 1'b1};
  localparam memCmd_t CMD_NOP   = '{csN: 1'b0, rasN: 1'b1, casN: 1'b1, weN: 1'b1};
  localparam memCmd_t CMD_PREA  = '{csN: 1'b0, rasN: 1'b0, casN: 1'b1, weN: 1'b0};
  localparam memCmd_t CMD_REF   = '{csN: 1'b0, rasN: 1'b0, casN: 1'b0, weN: 1'b1};
  localparam memCmd_t CMD_LMR   = '{csN: 1'b0, rasN: 1'b0, casN: 1'b0, weN: 1'b0};

endpackage

// File: rtl/lpd_init_ctrl.sv
module lpd_init_ctrl
  import lpd_init_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostModeWr,
  input  logic [2:0] hostModeCode,
  input  logic       hostAck,
  input  logic       waitDone,
  output seqStrobe_t strb,
  output logic       initReady
);

  seqState_e  state, nextState, effState;
  logic [2:0] codeReg;
  logic       accepting;

  function automatic logic [2:0] expCode(seqState_e s);
    case (s)
      ST_NOP:           return CODE_NOP;
      ST_PREA:          return CODE_PREA;
      ST_REF1, ST_REF2: return CODE_REF;
      ST_EMRS:          return CODE_EMRS;
      ST_MRS:           return CODE_MRS;
      default:          return 3'd0;
    endcase
  endfunction

  always_comb begin
    strb      = '0;
    effState  = (state == ST_WAIT && waitDone) ? ST_PREA : state;
    nextState = effState;
    accepting = (effState != ST_READY) && (effState != ST_WAIT);
    if (hostAck) begin
      if (accepting && codeReg == expCode(effState)) begin
        case (effState)
          ST_NOP:  begin strb.issueNop  = 1'b1; nextState = ST_WAIT;  end
          ST_PREA: begin strb.issuePrea = 1'b1; nextState = ST_REF1;  end
          ST_REF1: begin strb.issueRef  = 1'b1; nextState = ST_REF2;  end
          ST_REF2: begin strb.issueRef  = 1'b1; nextState = ST_EMRS;  end
          ST_EMRS: begin strb.issueEmrs = 1'b1; nextState = ST_MRS;   end
          ST_MRS:  begin strb.issueMrs  = 1'b1; nextState = ST_READY; end
          default: strb.flagError = 1'b1;
        endcase
      end else begin
        strb.flagError = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_NOP;
      codeReg <= 3'd0;
    end else begin
      state <= nextState;
      if (hostModeWr) codeReg <= hostModeCode;
    end
  end

  assign initReady = (state == ST_READY);

  AST_READY_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    initReady |=> initReady); // R11

  AST_ERROR_HOLDS_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.flagError && state != ST_WAIT) |=> (state == $past(state))); // R10

  AST_READY_ONLY_AFTER_MRS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(initReady) |-> $past(strb.issueMrs)); // R11

endmodule

// File: rtl/lpd_init_dpath.sv
module lpd_init_dpath
  import lpd_init_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int REF_W       = 16,
  parameter int WAIT_CYCLES = 20000
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic              initReady,
  input  logic [ADDR_W-1:0] extModeBits,
  input  logic [ADDR_W-1:0] modeBits,
  input  logic [REF_W-1:0]  refreshCount,
  output logic              waitDone,
  output logic              memCke,
  output memCmd_t           memCmd,
  output logic [1:0]        memBa,
  output logic [ADDR_W-1:0] memAddr,
  output logic              refreshReq,
  output logic              seqError
);

  localparam int WAIT_W = $clog2(WAIT_CYCLES + 1);
  localparam logic [WAIT_W-1:0] WAIT_LOAD = WAIT_W'(WAIT_CYCLES);
  localparam logic [ADDR_W-1:0] PREA_ADDR = ADDR_W'(1) << 10;

  logic [WAIT_W-1:0] waitCnt;
  logic [REF_W-1:0]  refCnt;
  logic [REF_W-1:0]  refLoad;
  logic              ckeNext;

  assign waitDone = (waitCnt == '0);
  assign refLoad  = (refreshCount == '0) ? REF_W'(1) : refreshCount;
  assign ckeNext  = memCke | strb.issueNop;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      memCke  <= 1'b0;
      memCmd  <= CMD_DESEL;
      memBa   <= 2'b00;
      memAddr <= '0;
    end else begin
      memCke  <= ckeNext;
      memCmd  <= ckeNext ? CMD_NOP : CMD_DESEL;
      memBa   <= 2'b00;
      memAddr <= '0;
      if (strb.issuePrea) begin
        memCmd  <= CMD_PREA;
        memAddr <= PREA_ADDR;
      end else if (strb.issueRef) begin
        memCmd  <= CMD_REF;
      end else if (strb.issueEmrs) begin
        memCmd  <= CMD_LMR;
        memBa   <= 2'b10;
        memAddr <= extModeBits;
      end else if (strb.issueMrs) begin
        memCmd  <= CMD_LMR;
        memBa   <= 2'b00;
        memAddr <= modeBits;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      waitCnt <= '0;
    end else if (strb.issueNop) begin
      waitCnt <= WAIT_LOAD;
    end else if (!waitDone) begin
      waitCnt <= waitCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refCnt     <= '0;
      refreshReq <= 1'b0;
      seqError   <= 1'b0;
    end else begin
      seqError   <= strb.flagError;
      refreshReq <= 1'b0;
      if (strb.issueMrs) begin
        refCnt <= refLoad;
      end else if (initReady) begin
        if (refCnt <= REF_W'(1)) begin
          refCnt     <= refLoad;
          refreshReq <= 1'b1;
        end else begin
          refCnt <= refCnt - 1'b1;
        end
      end
    end
  end

  AST_HOLD_BLOCKS_CMDS: assert property (@(posedge clk) disable iff (!rstN)
    !waitDone |-> !(strb.issueNop | strb.issuePrea | strb.issueRef |
                    strb.issueEmrs | strb.issueMrs)); // R5

  AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    !memCmd.rasN |=> (memCmd.rasN && memCmd.casN && memCmd.weN)); // R3

  AST_CKE_NEVER_FALLS: assert property (@(posedge clk) disable iff (!rstN)
    memCke |=> memCke); // R4

  AST_REFRESH_GATED: assert property (@(posedge clk) disable iff (!rstN)
    refreshReq |-> initReady); // R12

  AST_MODE_LOAD_BANK: assert property (@(posedge clk) disable iff (!rstN)
    (!memCmd.rasN && !memCmd.casN && !memCmd.weN) |-> !memBa[0]); // R8

endmodule

// File: rtl/lpd_init_sequencer.sv
module lpd_init_sequencer
  import lpd_init_pkg::*;
#(
  parameter int CLK_MHZ = 100,
  parameter int WAIT_US = 200,
  parameter int ADDR_W  = 13,
  parameter int REF_W   = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostModeWr,
  input  logic [2:0]        hostModeCode,
  input  logic              hostAck,
  input  logic [ADDR_W-1:0] extModeBits,
  input  logic [ADDR_W-1:0] modeBits,
  input  logic [REF_W-1:0]  refreshCount,
  output logic              memCke,
  output logic              memCsN,
  output logic              memRasN,
  output logic              memCasN,
  output logic              memWeN,
  output logic [1:0]        memBa,
  output logic [ADDR_W-1:0] memAddr,
  output logic              initReady,
  output logic              refreshReq,
  output logic              seqError
);

  localparam int WAIT_CYCLES = CLK_MHZ * WAIT_US;

  seqStrobe_t strb;
  memCmd_t    memCmd;
  logic       waitDone;

  lpd_init_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .hostModeWr   (hostModeWr),
    .hostModeCode (hostModeCode),
    .hostAck      (hostAck),
    .waitDone     (waitDone),
    .strb         (strb),
    .initReady    (initReady)
  );

  lpd_init_dpath #(
    .ADDR_W      (ADDR_W),
    .REF_W       (REF_W),
    .WAIT_CYCLES (WAIT_CYCLES)
  ) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .initReady    (initReady),
    .extModeBits  (extModeBits),
    .modeBits     (modeBits),
    .refreshCount (refreshCount),
    .waitDone     (waitDone),
    .memCke       (memCke),
    .memCmd       (memCmd),
    .memBa        (memBa),
    .memAddr      (memAddr),
    .refreshReq   (refreshReq),
    .seqError     (seqError)
  );

  assign memCsN  = memCmd.csN;
  assign memRasN = memCmd.rasN;
  assign memCasN = memCmd.casN;
  assign memWeN  = memCmd.weN;

endmodule

// File: tb/lpd_init_sequencer_tb.sv
module lpd_init_sequencer_tb;

  localparam int CLK_MHZ = 50;
  localparam int WAIT_US = 1;
  localparam int WAITC   = CLK_MHZ * WAIT_US;
  localparam int ADDR_W  = 13;
  localparam int REF_W   = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostModeWr = 1'b0;
  logic [2:0] hostModeCode = 3'd0;
  logic hostAck = 1'b0;
  logic [ADDR_W-1:0] extModeBits = 13'h0A5;
  logic [ADDR_W-1:0] modeBits = 13'h032;
  logic [REF_W-1:0] refreshCount = 16'd7;
  logic memCke, memCsN, memRasN, memCasN, memWeN;
  logic [1:0] memBa;
  logic [ADDR_W-1:0] memAddr;
  logic initReady, refreshReq, seqError;

  always #10 clk = ~clk;

  lpd_init_sequencer #(.CLK_MHZ(CLK_MHZ), .WAIT_US(WAIT_US), .ADDR_W(ADDR_W), .REF_W(REF_W)) u_dut (
    .clk(clk), .rstN(rstN), .hostModeWr(hostModeWr), .hostModeCode(hostModeCode),
    .hostAck(hostAck), .extModeBits(extModeBits), .modeBits(modeBits),
    .refreshCount(refreshCount), .memCke(memCke), .memCsN(memCsN), .memRasN(memRasN),
    .memCasN(memCasN), .memWeN(memWeN), .memBa(memBa), .memAddr(memAddr),
    .initReady(initReady), .refreshReq(refreshReq), .seqError(seqError));

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic mCke, mCs, mRas, mCas, mWe, mReady, mReq, mErr;
  logic [1:0] mBa;
  logic [ADDR_W-1:0] mAddr;
  logic [2:0] mCode;
  int mStep, mWait, mRef;
  int st, nxt, loadN;
  bit iss, ckeN;

  function automatic int stepCode(int s);
    case (s)
      0: return 1;
      2: return 2;
      3, 4: return 4;
      5: return 5;
      6: return 3;
      default: return -1;
    endcase
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mCke <= 0; mCs <= 1; mRas <= 1; mCas <= 1; mWe <= 1; mBa <= 0; mAddr <= 0;
      mReady <= 0; mReq <= 0; mErr <= 0; mCode <= 0; mStep <= 0; mWait <= 0; mRef <= 0;
    end else begin
      st = (mStep == 1 && mWait == 0) ? 2 : mStep;
      nxt = st;
      iss = 0;
      if (hostAck) begin
        if (st == 1 || st == 7 || int'(mCode) != stepCode(st)) mErr <= 1;
        else iss = 1;
      end
      if (!hostAck || iss) mErr <= 0;
      ckeN = mCke || (iss && st == 0);
      mCke <= ckeN;
      mCs <= !ckeN; mRas <= 1; mCas <= 1; mWe <= 1; mBa <= 0; mAddr <= 0;
      if (iss) begin
        nxt = st + 1;
        case (st)
          2: begin mRas <= 0; mWe <= 0; mAddr <= 13'h400; end
          3, 4: begin mRas <= 0; mCas <= 0; end
          5: begin mRas <= 0; mCas <= 0; mWe <= 0; mBa <= 2; mAddr <= extModeBits; end
          6: begin mRas <= 0; mCas <= 0; mWe <= 0; mBa <= 0; mAddr <= modeBits; end
          default: ;
        endcase
      end
      if (iss && st == 0) mWait <= WAITC;
      else if (mWait > 0) mWait <= mWait - 1;
      loadN = (refreshCount == 0) ? 1 : int'(refreshCount);
      mReq <= 0;
      if (iss && st == 6) begin
        mRef <= loadN; mReady <= 1;
      end else if (mReady) begin
        if (mRef <= 1) begin mRef <= loadN; mReq <= 1; end
        else mRef <= mRef - 1;
      end
      if (hostModeWr) mCode <= hostModeCode;
      mStep <= nxt;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      chk(memCke == mCke, "R4 cke", memCke, mCke);
      chk({memCsN, memRasN, memCasN, memWeN} == {mCs, mRas, mCas, mWe}, "R3 command",
          {memCsN, memRasN, memCasN, memWeN}, {mCs, mRas, mCas, mWe});
      chk(memBa == mBa, "R8 bank", memBa, mBa);
      chk(memAddr == mAddr, "R9 addr", memAddr, mAddr);
      chk(initReady == mReady, "R11 ready", initReady, mReady);
      chk(refreshReq == mReq, "R12 refresh", refreshReq, mReq);
      chk(seqError == mErr, "R10 error", seqError, mErr);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 100000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  task automatic doWrite(input logic [2:0] code);
    hostModeWr = 1; hostModeCode = code;
    @(negedge clk);
    hostModeWr = 0;
  endtask

  task automatic doAck();
    hostAck = 1;
    @(negedge clk);
    hostAck = 0;
  endtask

  int pulses;

  initial begin
    repeat (3) @(negedge clk);
    chk({memCke, memCsN, memRasN, memCasN, memWeN} == 5'b01111, "R1 bus at reset",
        {memCke, memCsN, memRasN, memCasN, memWeN}, 5'b01111);
    chk({memBa, memAddr, initReady, refreshReq, seqError} == '0, "R1 outputs at reset",
        {memBa, memAddr, initReady, refreshReq, seqError}, 0);
    rstN = 1;
    @(negedge clk);
    doAck();                                  // no code stored
    chk(seqError == 1 && memCke == 0, "R10 ack without code", {seqError, memCke}, 2'b10);
    doWrite(3'd1);
    doAck();
    chk(memCke == 1 && memCsN == 0, "R2 R4 NOP raises cke", {memCke, memCsN}, 2'b10);
    doWrite(3'd2);
    doAck();                                  // during hold
    chk(seqError == 1 && memRasN == 1, "R5 ack in hold", {seqError, memRasN}, 2'b11);
    repeat (WAITC - 3) @(negedge clk);
    doAck();                                  // last rejected edge
    chk(seqError == 1 && memRasN == 1, "R5 last hold edge", {seqError, memRasN}, 2'b11);
    doAck();                                  // first accepted edge
    chk(memRasN == 0 && memWeN == 0 && memCasN == 1, "R5 R6 precharge issued",
        {memRasN, memCasN, memWeN}, 3'b010);
    chk(memAddr == 13'h400 && memBa == 0, "R6 A10 high", memAddr, 13'h400);
    doWrite(3'd4);
    doAck();
    chk(memRasN == 0 && memCasN == 0 && memWeN == 1, "R7 first refresh",
        {memRasN, memCasN, memWeN}, 3'b001);
    @(negedge clk);
    doAck();
    chk(memRasN == 0 && memCasN == 0 && memWeN == 1, "R7 second refresh",
        {memRasN, memCasN, memWeN}, 3'b001);
    doWrite(3'd3);
    doAck();                                  // standard load before extended
    chk(seqError == 1 && memRasN == 1, "R10 out of order", {seqError, memRasN}, 2'b11);
    doWrite(3'd5);
    doAck();
    chk(memBa == 2'b10 && memAddr == extModeBits && initReady == 0, "R8 extended load",
        memBa, 2'b10);
    doWrite(3'd3);
    doAck();
    chk(memBa == 2'b00 && memAddr == modeBits && initReady == 1, "R9 R11 standard load",
        memAddr, modeBits);
    pulses = 0;
    for (int i = 0; i < 21; i++) begin
      @(negedge clk);
      if (refreshReq) pulses++;
    end
    chk(pulses == 3, "R12 three pulses at N=7", pulses, 3);
    refreshCount = 16'd3;
    repeat (20) @(negedge clk);
    doWrite(3'd4);
    doAck();                                  // after ready
    chk(seqError == 1 && memRasN == 1, "R10 ack after ready", {seqError, memRasN}, 2'b11);
    refreshCount = 16'd0;
    repeat (12) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule